// File: doc/BRIEF.md
# Per-Core Idle State Predictor

This block decides, for every core of a multicore cluster, whether the core should run at a reduced idle frequency or at its normal configured frequency. A periodic evaluation tick (a single-cycle strobe, typically one every couple of microseconds of wall time) makes the block sample a one-bit idle flag from each core. Any non-idle condition, such as running, stalled, sleeping or waking, is presented as 0. Each core has its own table row. The row holds a short shift history of past idle flags, a saturating confidence counter, the outstanding prediction and a two-state lane mode.

On a tick, every core is evaluated in parallel within the same clock. The stored prediction is compared with the sampled flag. Confidence is cleared on a miss and otherwise climbs toward the threshold. The new flag is shifted into the history, and a fresh prediction is formed from the most recent bits. The lane mode is either LEARN, where the frequency is left alone, or SPEC, where the frequency follows the prediction. LEARN moves to SPEC when confidence after the update is at or above the threshold. SPEC moves back to LEARN when confidence falls below the threshold, which only a miss can cause at a fixed threshold. On that SPEC to LEARN transition the frequency is put back to match the real sampled state. SPEC stays in SPEC while predictions keep hitting, and LEARN stays in LEARN until enough hits have been seen. Two free-running counters give the number of evaluated predictions and the number of correct ones, so a power manager can compute accuracy.

Top module: `core_idle_predictor`

## Requirements
- R1: After reset every core's select is the configured code (`freq_sel` slice equals `freq_cfg`), both counters read 0, every history bit is not-idle (0), and every lane is in LEARN with confidence 0, so the first prediction is "not idle".
- R2: Core status is one bit, 1 meaning idle. On each tick the sampled bit is shifted into that core's history as the newest entry. With an effective depth of 1 the prediction equals the last sampled bit.
- R3: The prediction is the majority of the newest D history bits, where D is `hist_depth` clamped to the range 1..MAX_HIST (0 counts as 1). A tie resolves to the newest bit.
- R4: On a tick, a miss (prediction differs from the sampled bit) clears that core's confidence to 0. A hit adds 1 only while confidence is below `conf_thresh`, so confidence saturates at the threshold.
- R5: If confidence after the update is at or above `conf_thresh`, the core enters or stays in SPEC. Its select then becomes `freq_idle` when the new prediction is idle and `freq_cfg` otherwise.
- R6: A SPEC lane whose updated confidence drops below the threshold returns to LEARN. Its select is set to the code matching the sampled state: idle gives `freq_idle`, not idle gives `freq_cfg`. A lane in LEARN that stays in LEARN keeps its select.
- R7: With `conf_thresh` equal to 0, every tick applies the new prediction to the select, including the first tick after reset.
- R8: On cycles without a tick, no history, confidence, prediction, select or counter changes, whatever `core_idle` does.
- R9: Each tick adds NUM_CORES to `pred_total` and adds the number of hits among the cores to `pred_correct`. Both counters wrap modulo 2^CNT_W.
- R10: Selects are registered one clock after the tick edge. The output code of each core is the configured or idle code chosen by that registered select. Core i occupies bits [i*FREQ_W +: FREQ_W] of `freq_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle evaluation strobe |
| core_idle | input | NUM_CORES | Per-core status, 1 = idle, 0 = any other state |
| conf_thresh | input | CONF_W | Confidence threshold for speculation |
| hist_depth | input | DEPTH_W | Number of history bits used in the vote (clamped 1..MAX_HIST) |
| freq_idle | input | FREQ_W | Frequency code used when idle is predicted |
| freq_cfg | input | FREQ_W | Configured (normal) frequency code |
| freq_sel | output | NUM_CORES*FREQ_W | Per-core frequency code, core i at [i*FREQ_W +: FREQ_W] |
| pred_total | output | CNT_W | Count of evaluated predictions |
| pred_correct | output | CNT_W | Count of correct predictions |

## Verification
All results of a tick are due after exactly one clock edge: a tick driven in one cycle is captured at the next rising edge, and the selects, counters and internal lane state reflect it from then on. The bench drives the tick and core flags on a falling edge, drops the tick at the following falling edge, and compares the outputs against its own model at that point. It then runs one idle cycle with inverted core flags and compares again, which confirms that nothing moves without a tick. Sweeps cover every depth from 0 to 5 and every threshold from 0 to 3, with several per-core activity patterns. The model is stepped once per tick, so the expected value always corresponds to the edge just passed.

// File: rtl/cip_pkg.sv
package cip_pkg;

    // Lane mode: LEARN leaves the select alone, SPEC drives it from the prediction
    typedef enum logic {
        LANE_LEARN = 1'b0,
        LANE_SPEC  = 1'b1
    } lane_state_e;

endpackage

// File: rtl/cip_history_vote.sv
module cip_history_vote #(
    parameter int MAX_HIST = 4,
    parameter int DEPTH_W  = $clog2(MAX_HIST + 1)
) (
    input  logic [MAX_HIST-1:0] hist,      // bit 0 is the newest sample
    input  logic [DEPTH_W-1:0]  depth,
    output logic                vote_idle
);

    localparam int SW = DEPTH_W + 2;

    logic [SW-1:0] eff_depth;
    logic [SW-1:0] ones;
    logic [SW-1:0] twice;

    // Clamp the requested depth into 1..MAX_HIST
    always_comb begin
        if (depth == '0) begin
            eff_depth = SW'(1);
        end else if (SW'(depth) > SW'(MAX_HIST)) begin
            eff_depth = SW'(MAX_HIST);
        end else begin
            eff_depth = SW'(depth);
        end
    end

    // Population count over the newest eff_depth bits
    always_comb begin
        ones = '0;
        for (int k = 0; k < MAX_HIST; k++) begin
            if (SW'(k) < eff_depth) begin
                ones = ones + SW'(hist[k]);
            end
        end
    end

    assign twice = ones << 1;

    // Majority, tie goes to the newest bit
    always_comb begin
        if (twice > eff_depth) begin
            vote_idle = 1'b1;
        end else if (twice == eff_depth) begin
            vote_idle = hist[0];
        end else begin
            vote_idle = 1'b0;
        end
    end

endmodule

// File: rtl/cip_core_lane.sv
module cip_core_lane
    import cip_pkg::*;
#(
    parameter int MAX_HIST = 4,
    parameter int DEPTH_W  = $clog2(MAX_HIST + 1),
    parameter int CONF_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                actual_idle,
    input  logic [CONF_W-1:0]   thresh,
    input  logic [DEPTH_W-1:0]  depth,
    output logic                sel_idle,
    output logic                miss,
    output logic                pred,
    output logic [CONF_W-1:0]   conf,
    output lane_state_e         state
);

    lane_state_e          state_q, state_d;
    logic [MAX_HIST-1:0]  hist_q, hist_d, hist_shift;
    logic [CONF_W-1:0]    conf_q, conf_d, conf_upd;
    logic                 pred_q, pred_d;
    logic                 sel_q, sel_d;
    logic                 vote_next;
    logic                 reach;

    // Newest sample enters at bit 0
    generate
        if (MAX_HIST == 1) begin : g_single
            assign hist_shift = actual_idle;
        end else begin : g_multi
            assign hist_shift = {hist_q[MAX_HIST-2:0], actual_idle};
        end
    endgenerate

    cip_history_vote #(
        .MAX_HIST (MAX_HIST),
        .DEPTH_W  (DEPTH_W)
    ) i_vote (
        .hist      (hist_shift),
        .depth     (depth),
        .vote_idle (vote_next)
    );

    assign miss = pred_q ^ actual_idle;

    // Confidence after checking the outstanding prediction
    always_comb begin
        if (miss) begin
            conf_upd = '0;
        end else if (conf_q < thresh) begin
            conf_upd = conf_q + CONF_W'(1);
        end else begin
            conf_upd = conf_q;
        end
    end

    assign reach = (conf_upd >= thresh);

    // Next-state and output decisions
    always_comb begin
        state_d = state_q;
        hist_d  = hist_q;
        conf_d  = conf_q;
        pred_d  = pred_q;
        sel_d   = sel_q;
        if (tick) begin
            hist_d = hist_shift;
            conf_d = conf_upd;
            pred_d = vote_next;
            unique case (state_q)
                LANE_LEARN: begin
                    if (reach) begin
                        state_d = LANE_SPEC;
                        sel_d   = vote_next;
                    end
                end
                LANE_SPEC: begin
                    if (reach) begin
                        sel_d = vote_next;
                    end else begin
                        state_d = LANE_LEARN;
                        if (miss) begin
                            sel_d = actual_idle;
                        end
                    end
                end
                default: state_d = LANE_LEARN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_LEARN;
            hist_q  <= '0;
            conf_q  <= '0;
            pred_q  <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hist_q  <= hist_d;
            conf_q  <= conf_d;
            pred_q  <= pred_d;
            sel_q   <= sel_d;
        end
    end

    assign sel_idle = sel_q;
    assign pred     = pred_q;
    assign conf     = conf_q;
    assign state    = state_q;

endmodule

// File: rtl/cip_accuracy.sv
module cip_accuracy #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_CORES-1:0] miss_vec,
    output logic [CNT_W-1:0]     total,
    output logic [CNT_W-1:0]     correct
);

    localparam int HW = $clog2(NUM_CORES + 1);

    logic [HW-1:0]    hits;
    logic [CNT_W-1:0] total_q, correct_q;

    always_comb begin
        hits = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            hits = hits + HW'(~miss_vec[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q   <= '0;
            correct_q <= '0;
        end else if (tick) begin
            total_q   <= total_q + CNT_W'(NUM_CORES);
            correct_q <= correct_q + CNT_W'(hits);
        end
    end

    assign total   = total_q;
    assign correct = correct_q;

endmodule

// File: rtl/core_idle_predictor.sv
module core_idle_predictor
    import cip_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int MAX_HIST  = 4,
    parameter int CONF_W    = 3,
    parameter int FREQ_W    = 8,
    parameter int CNT_W     = 16,
    parameter int DEPTH_W   = $clog2(MAX_HIST + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [NUM_CORES-1:0]          core_idle,
    input  logic [CONF_W-1:0]             conf_thresh,
    input  logic [DEPTH_W-1:0]            hist_depth,
    input  logic [FREQ_W-1:0]             freq_idle,
    input  logic [FREQ_W-1:0]             freq_cfg,
    output logic [NUM_CORES*FREQ_W-1:0]   freq_sel,
    output logic [CNT_W-1:0]              pred_total,
    output logic [CNT_W-1:0]              pred_correct
);

    logic [NUM_CORES-1:0]        sel_vec;
    logic [NUM_CORES-1:0]        miss_vec;
    logic [NUM_CORES-1:0]        pred_vec;
    logic [NUM_CORES-1:0]        spec_vec;
    logic [NUM_CORES*CONF_W-1:0] conf_flat;

    generate
        for (genvar i = 0; i < NUM_CORES; i++) begin : g_lane
            lane_state_e        lane_state;
            logic [CONF_W-1:0]  lane_conf;

            cip_core_lane #(
                .MAX_HIST (MAX_HIST),
                .DEPTH_W  (DEPTH_W),
                .CONF_W   (CONF_W)
            ) i_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick        (tick),
                .actual_idle (core_idle[i]),
                .thresh      (conf_thresh),
                .depth       (hist_depth),
                .sel_idle    (sel_vec[i]),
                .miss        (miss_vec[i]),
                .pred        (pred_vec[i]),
                .conf        (lane_conf),
                .state       (lane_state)
            );

            assign spec_vec[i]                   = (lane_state == LANE_SPEC);
            assign conf_flat[i*CONF_W +: CONF_W] = lane_conf;
            assign freq_sel[i*FREQ_W +: FREQ_W]  = sel_vec[i] ? freq_idle : freq_cfg;
        end
    endgenerate

    cip_accuracy #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W)
    ) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .miss_vec (miss_vec),
        .total    (pred_total),
        .correct  (pred_correct)
    );

endmodule

// File: rtl/cip_checker.sv
module cip_checker #(
    parameter int NUM_CORES = 4,
    parameter int CONF_W    = 3,
    parameter int CNT_W     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic [NUM_CORES-1:0]        core_idle,
    input logic [CONF_W-1:0]           conf_thresh,
    input logic [NUM_CORES-1:0]        sel_vec,
    input logic [NUM_CORES-1:0]        pred_vec,
    input logic [NUM_CORES-1:0]        spec_vec,
    input logic [NUM_CORES*CONF_W-1:0] conf_flat,
    input logic [CNT_W-1:0]            pred_total,
    input logic [CNT_W-1:0]            pred_correct
);

    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pred_total == $past(pred_total) + CNT_W'(NUM_CORES)); // R9

    AST_CORRECT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pred_correct - $past(pred_correct)) <= CNT_W'(NUM_CORES)); // R9

    AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sel_vec) && $stable(conf_flat) && $stable(pred_total)); // R8

    generate
        for (genvar i = 0; i < NUM_CORES; i++) begin : g_lane_chk
            AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                tick && (pred_vec[i] != core_idle[i])
                |=> conf_flat[i*CONF_W +: CONF_W] == '0); // R4

            AST_HIT_CLIMBS: assert property (@(posedge clk) disable iff (!rst_n)
                tick && (pred_vec[i] == core_idle[i])
                && (conf_flat[i*CONF_W +: CONF_W] < conf_thresh)
                |=> conf_flat[i*CONF_W +: CONF_W]
                    == $past(conf_flat[i*CONF_W +: CONF_W]) + CONF_W'(1)); // R4

            AST_SPEC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !spec_vec[i] || (sel_vec[i] == pred_vec[i])); // R5

            AST_MISS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
                tick && spec_vec[i] && (pred_vec[i] != core_idle[i]) && (conf_thresh != '0)
                |=> sel_vec[i] == $past(core_idle[i])); // R6

            AST_ZERO_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
                tick && (conf_thresh == '0) |=> spec_vec[i]); // R7
        end
    endgenerate

endmodule

bind core_idle_predictor cip_checker #(
    .NUM_CORES (NUM_CORES),
    .CONF_W    (CONF_W),
    .CNT_W     (CNT_W)
) i_cip_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .core_idle    (core_idle),
    .conf_thresh  (conf_thresh),
    .sel_vec      (sel_vec),
    .pred_vec     (pred_vec),
    .spec_vec     (spec_vec),
    .conf_flat    (conf_flat),
    .pred_total   (pred_total),
    .pred_correct (pred_correct)
);

// File: tb/test_core_idle_predictor.sv
module test_core_idle_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int MH  = 4;
    localparam int CW  = 3;
    localparam int FW  = 8;
    localparam int KW  = 16;
    localparam int DW  = $clog2(MH + 1);
    localparam logic [FW-1:0] F_IDLE = 8'hA5;
    localparam logic [FW-1:0] F_CFG  = 8'h3C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [NC-1:0]     core_idle = '0;
    logic [CW-1:0]     conf_thresh = '0;
    logic [DW-1:0]     hist_depth = DW'(1);
    logic [NC*FW-1:0]  freq_sel;
    logic [KW-1:0]     pred_total, pred_correct;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    // bench model
    logic [MH-1:0] m_hist [NC];
    int            m_conf [NC];
    bit            m_pred [NC];
    bit            m_spec [NC];
    bit            m_sel  [NC];
    string         m_tag  [NC];
    int            m_tot, m_cor;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_idle_predictor #(
        .NUM_CORES (NC), .MAX_HIST (MH), .CONF_W (CW), .FREQ_W (FW), .CNT_W (KW)
    ) i_core_idle_predictor (
        .clk (clk), .rst_n (rst_n), .tick (tick), .core_idle (core_idle),
        .conf_thresh (conf_thresh), .hist_depth (hist_depth),
        .freq_idle (F_IDLE), .freq_cfg (F_CFG),
        .freq_sel (freq_sel), .pred_total (pred_total), .pred_correct (pred_correct)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // majority of newest d bits, tie to newest (R3)
    function automatic bit b_majority(logic [MH-1:0] h, int d);
        int eff = (d < 1) ? 1 : ((d > MH) ? MH : d);
        int ones = 0;
        for (int k = 0; k < eff; k++) ones += int'(h[k]);
        if (2*ones > eff) return 1'b1;
        if (2*ones == eff) return h[0];
        return 1'b0;
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < NC; c++) begin
            m_hist[c] = '0; m_conf[c] = 0; m_pred[c] = 0; m_spec[c] = 0; m_sel[c] = 0;
            m_tag[c] = "R1";
        end
        m_tot = 0; m_cor = 0;
    endfunction

    function automatic void model_tick(logic [NC-1:0] idl, int th, int d);
        for (int c = 0; c < NC; c++) begin
            bit act = idl[c];
            bit mis = (m_pred[c] != act);
            bit was_spec = m_spec[c];
            m_tot++;
            if (!mis) m_cor++;
            if (mis) m_conf[c] = 0;                 // R4
            else if (m_conf[c] < th) m_conf[c]++;
            m_hist[c] = {m_hist[c][MH-2:0], act};  // R2
            m_pred[c] = b_majority(m_hist[c], d);  // R3
            m_spec[c] = (m_conf[c] >= th);
            if (m_spec[c]) begin
                m_sel[c] = m_pred[c];
                m_tag[c] = (th == 0) ? "R7" : ((d <= 1) ? "R5 R2" : "R5 R3");
            end else if (was_spec && mis) begin
                m_sel[c] = act;                      // R6
                m_tag[c] = "R6 R4";
            end else begin
                m_tag[c] = "R4 R6";
            end
        end
        m_tot = m_tot & 32'hFFFF; m_cor = m_cor & 32'hFFFF;
    endfunction

    task automatic compare_all(input string extra);
        for (int c = 0; c < NC; c++) begin
            logic [FW-1:0] exp = m_sel[c] ? F_IDLE : F_CFG;
            chk(freq_sel[c*FW +: FW] == exp, {m_tag[c], " R10 ", extra},
                32'(freq_sel[c*FW +: FW]), 32'(exp));
        end
        chk(pred_total == KW'(m_tot), {"R9 total ", extra}, 32'(pred_total), 32'(m_tot));
        chk(pred_correct == KW'(m_cor), {"R9 correct ", extra}, 32'(pred_correct), 32'(m_cor));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        compare_all("reset");   // R1
    endtask

    task automatic do_tick(input logic [NC-1:0] idl);
        tick = 1'b1; core_idle = idl;
        @(negedge clk);
        tick = 1'b0;
        model_tick(idl, int'(conf_thresh), int'(hist_depth));
        compare_all("tick");
        core_idle = ~idl;        // R8: flags move with no tick
        @(negedge clk);
        compare_all("R8 hold");
    endtask

    initial begin
        logic [7:0] lfsr = 8'h5B;
        for (int d = 0; d <= 5; d++) begin
            for (int th = 0; th <= 3; th++) begin
                hist_depth  = DW'(d);
                conf_thresh = CW'(th);
                do_reset();
                for (int t = 0; t < 40; t++) begin
                    logic [NC-1:0] idl;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    idl[0] = lfsr[0];                       // irregular
                    idl[1] = (t >= 10) && (t < 30);         // long idle stretch
                    idl[2] = t[0];                          // alternating
                    idl[3] = ((t % 5) < 3);                 // runs of 3 idle, 2 busy
                    do_tick(idl);
                end
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule